// File: doc/BRIEF.md
# Masked Interrupt Level Priority Encoder

This block gathers thirteen level-sensitive interrupt lines from board devices and presents one 4-bit encoded interrupt level to the CPU. Each line drives one bit of a 16-bit monitor word. A software-writable enable word gates the monitor word. Among the lines that are both high and enabled, the block picks the one with the smallest priority number. It registers the bit-inverted form of that number on the level output, so an idle system reads zero and the most urgent line reads fifteen.

A small 16-bit register window sits beside the encoder. It holds the enable word, a general-purpose 16-bit output latch, a power-down command register that fires a one-cycle shutdown strobe, and a fixed revision word. The window takes a simple select/write strobe with a 6-bit byte offset and returns read data combinationally. Input `irq_in[k]` is the line whose priority number is k.

Top module: `irl_prio_agg`

## Requirements
- R1: Each input `irq_in[k]` maps to one monitor/enable bit position by priority number k: 0→11, 1→9, 2→8, 3→12, 4→10, 5→6, 6→5, 7→4, 8→7, 9→14, 10→13, 11→0, 12→15. Bits 1, 2 and 3 have no source.
- R2: The inputs are level-sensitive and nothing latches them. A line that falls stops competing at once.
- R3: A line competes only when its input is high and its enable bit is 1.
- R4: The winning level is the smallest competing priority number, or 15 when no line competes. `irl_out` equals that level XOR 15: an idle system gives 0 and priority 0 gives 15.
- R5: `irl_out` is a register. It shows the result for the inputs and enable word that were present at the previous rising clock edge.
- R6: The enable word is at offset 0x00. It can be read and written, and it resets to 0, which masks every line.
- R7: The output latch is at offset 0x36. It can be read and written, it drives `gp_out`, and it resets to 0.
- R8: The power-down register at offset 0x30 always reads 0. A write with bit 0 set raises `shutdown_req` for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R9: The revision register at offset 0x32 reads 0x0010 and ignores writes.
- R10: Any other offset in the 0x40-byte window, and any odd offset, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 13 | Interrupt lines, index = priority number |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |
| irl_out | output | 4 | Registered inverted winning level |
| shutdown_req | output | 1 | One-cycle power-down strobe |
| gp_out | output | 16 | Contents of the output latch |

## Verification
The assertions assume that the interrupt lines and the bus strobes are stable around the rising edge. They also assume that every qualifying power-down write is a bus transaction lasting a single cycle. The bench drives every input at the falling edge, holds each write strobe for exactly one cycle, and leaves at least one idle cycle between bus operations. The random phase draws both the line patterns and the enable words from the full 13-bit and 16-bit ranges, including the sourceless bits.

// File: rtl/irl_agg_pkg.sv
// Shared constants for the interrupt level aggregator.
// Assumes a 16-bit register window addressed by byte offset.
package irl_agg_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned NUM_SRC = 13;
    localparam int unsigned LVL_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWRDN  = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_REV    = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_GPOUT  = 6'h36;
    localparam logic [DATA_W-1:0] REV_VALUE  = 16'h0010;

    // Monitor/enable bit owned by the line of priority number k.
    function automatic int unsigned src_bit(int unsigned k);
        case (k)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/irl_src_map.sv
// Places each level-sensitive interrupt line on its monitor bit.
// Assumes the lines are already synchronous to clk; there is no latching.
module irl_src_map
    import irl_agg_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC,
    parameter int unsigned W     = DATA_W
) (
    input  logic [N_SRC-1:0] lines,
    output logic [W-1:0]     mon_word
);
    // Scatter the lines into the monitor word; sourceless bits stay 0.
    always_comb begin
        mon_word = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            mon_word[src_bit(i)] = lines[i];
        end
    end
endmodule

// File: rtl/irl_prio_enc.sv
// Picks the smallest competing priority number and registers its
// inverted value. Assumes the monitor and enable words share bit positions.
module irl_prio_enc
    import irl_agg_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC,
    parameter int unsigned W     = DATA_W,
    parameter int unsigned LW    = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  mon_word,
    input  logic [W-1:0]  en_word,
    output logic [LW-1:0] irl_q
);
    localparam logic [LW-1:0] IDLE_LVL = LW'((1 << LW) - 1);

    logic [N_SRC-1:0] active;
    logic [LW-1:0]    win_lvl;

    // Gate each line by its enable bit at its own position.
    for (genvar g = 0; g < int'(N_SRC); g++) begin : g_act
        localparam int unsigned B = src_bit(g);
        assign active[g] = mon_word[B] & en_word[B];
    end

    // Scan from the highest number down so the smallest competing one wins.
    always_comb begin
        win_lvl = IDLE_LVL;
        for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
            if (active[i]) win_lvl = LW'(i);
        end
    end

    // Register the inverted winning level.
    always_ff @(posedge clk) begin
        if (!rst_n) irl_q <= '0;
        else        irl_q <= win_lvl ^ IDLE_LVL;
    end

    // R4: priority 0 enabled and pending means the top code follows.
    assert_top_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mon_word[11] & en_word[11]) |-> irl_q == IDLE_LVL);
    // R3: a nonzero code needs some line that was pending and enabled.
    assert_needs_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irl_q != '0) |-> $past(|(mon_word & en_word)));
    // R4: nothing competing gives the idle code.
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|(mon_word & en_word)) |-> irl_q == '0);
endmodule

// File: rtl/irl_reg_window.sv
// 16-bit register window: enable word, output latch, power-down command,
// revision word. Assumes single-cycle strobes; reads are combinational.
module irl_reg_window
    import irl_agg_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  en_q,
    output logic [W-1:0]  gp_q,
    output logic          shdn_q
);
    logic wr_ok;
    logic pwr_hit;

    // Only even offsets form a legal 16-bit access.
    assign wr_ok   = sel & wr & ~addr[0];
    assign pwr_hit = wr_ok && (addr == OFS_PWRDN) && wdata[0];

    // Enable word and output latch storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            gp_q <= '0;
        end else if (wr_ok) begin
            if (addr == OFS_ENABLE) en_q <= wdata;
            if (addr == OFS_GPOUT)  gp_q <= wdata;
        end
    end

    // One-cycle power-down strobe per qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) shdn_q <= 1'b0;
        else        shdn_q <= pwr_hit;
    end

    // Read multiplexer; every other offset returns zero.
    always_comb begin
        rdata = '0;
        if (!addr[0]) begin
            case (addr)
                OFS_ENABLE: rdata = en_q;
                OFS_GPOUT:  rdata = gp_q;
                OFS_REV:    rdata = REV_VALUE;
                default:    rdata = '0;
            endcase
        end
    end

    // R6: the enable word is clear right after reset.
    assert_enable_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> en_q == '0);
    // R7: the output latch only moves on a write to its offset.
    assert_gp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && addr == OFS_GPOUT) |=> $stable(gp_q));
    // R8: a strobe always comes from a write with bit 0 set at the power-down offset.
    assert_shdn_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_q |-> $past(sel && wr && addr == OFS_PWRDN && wdata[0]));
    // R10: the enable word ignores writes elsewhere.
    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && addr == OFS_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/irl_prio_agg.sv
// Top of the interrupt level aggregator: line mapping, enable gating,
// priority encode and register window. Assumes all inputs are synchronous.
module irl_prio_agg
    import irl_agg_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC,
    parameter int unsigned W     = DATA_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned LW    = LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    output logic [LW-1:0]    irl_out,
    output logic             shutdown_req,
    output logic [W-1:0]     gp_out
);
    logic [W-1:0] mon_word;
    logic [W-1:0] en_word;

    irl_src_map #(.N_SRC(N_SRC), .W(W)) u_map (
        .lines    (irq_in),
        .mon_word (mon_word)
    );

    irl_reg_window #(.W(W), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .en_q   (en_word),
        .gp_q   (gp_out),
        .shdn_q (shutdown_req)
    );

    irl_prio_enc #(.N_SRC(N_SRC), .W(W), .LW(LW)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_word (mon_word),
        .en_word  (en_word),
        .irl_q    (irl_out)
    );
endmodule

// File: tb/irl_prio_agg_tb_top.sv
`timescale 1ns/1ps
module irl_prio_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irl_out;
    logic        shutdown_req;
    logic [15:0] gp_out;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] en_model = '0;

    always #2.5 clk = ~clk;

    irl_prio_agg dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irl_out(irl_out),
        .shutdown_req(shutdown_req), .gp_out(gp_out)
    );

    // Bit owned by priority k (R1 table).
    function automatic int exp_bit(int k);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[k];
    endfunction

    function automatic logic [3:0] exp_irl(logic [12:0] s, logic [15:0] m);
        for (int k = 0; k < 13; k++)
            if (s[k] && m[exp_bit(k)]) return 4'(k) ^ 4'hF;
        return 4'h0;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Present lines, wait two edges, compare the level code.
    task automatic irl_case(string req, logic [12:0] s);
        @(negedge clk);
        irq_in = s;
        @(negedge clk);
        @(negedge clk);
        check(req, {12'h0, irl_out}, {12'h0, exp_irl(s, en_model)});
    endtask

    initial begin
        logic [15:0] rd;
        void'($urandom(32'h0000_51A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 R8: reset state
        check("R4 reset irl", {12'h0, irl_out}, 16'h0);
        check("R8 reset strobe", {15'h0, shutdown_req}, 16'h0);
        check("R7 reset gp_out", gp_out, 16'h0);
        bus_read(6'h00, rd); check("R6 reset enable", rd, 16'h0);
        // R3: all lines high but masked
        irl_case("R3 all masked", 13'h1FFF);
        // R9: revision and write ignored
        bus_read(6'h32, rd); check("R9 revision", rd, 16'h0010);
        bus_write(6'h32, 16'hFFFF);
        bus_read(6'h32, rd); check("R9 write ignored", rd, 16'h0010);
        // R7: output latch
        bus_write(6'h36, 16'hA5C3);
        bus_read(6'h36, rd); check("R7 readback", rd, 16'hA5C3);
        check("R7 gp_out", gp_out, 16'hA5C3);
        // R6: enable word write and read
        bus_write(6'h00, 16'hFFFF); en_model = 16'hFFFF;
        bus_read(6'h00, rd); check("R6 enable readback", rd, 16'hFFFF);
        // R4: idle, top, lowest priorities
        irl_case("R4 idle", 13'h0);
        irl_case("R4 priority 0", 13'h1FFF);
        irl_case("R4 priority 12 alone", 13'h1000);
        irl_case("R1 priority 11 on bit 0", 13'h0800);
        // R2: line drops, no latch
        irl_case("R2 line dropped", 13'h0000);
        // R5: one edge latency after enable write
        @(negedge clk); irq_in = 13'h0004;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 16'h0100;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; en_model = 16'h0100;
        check("R5 before update", {12'h0, irl_out}, 16'h000D);
        @(negedge clk);
        check("R5 after update", {12'h0, irl_out}, 16'h000D);
        bus_write(6'h00, 16'hF7FF); en_model = 16'hF7FF;
        irl_case("R3 priority 0 masked", 13'h0003);
        // R8: power-down register
        bus_read(6'h30, rd); check("R8 reads zero", rd, 16'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 16'h0001;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        check("R8 pulse", {15'h0, shutdown_req}, 16'h1);
        @(negedge clk);
        check("R8 pulse one cycle", {15'h0, shutdown_req}, 16'h0);
        bus_write(6'h30, 16'hFFFE);
        check("R8 bit0 clear", {15'h0, shutdown_req}, 16'h0);
        // R10: unmapped and odd offsets
        bus_write(6'h02, 16'h1234);
        bus_read(6'h02, rd); check("R10 unmapped read", rd, 16'h0);
        bus_write(6'h01, 16'h0000);
        bus_read(6'h00, rd); check("R10 odd write ignored", rd, 16'hF7FF);
        bus_write(6'h37, 16'h0000);
        check("R10 odd gp write ignored", gp_out, 16'hA5C3);
        bus_read(6'h33, rd); check("R10 odd read", rd, 16'h0);
        // R1 R3 R4: random patterns
        for (int it = 0; it < 400; it++) begin
            if (($urandom % 3) == 0) begin
                logic [15:0] m;
                m = 16'($urandom);
                bus_write(6'h00, m); en_model = m;
            end
            irl_case("R1 R4 random", 13'($urandom));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule